// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit signed accumulator. The accumulator is kept as two 32-bit words: the high word holds bits 63..32 and the low word holds bits 31..0. A one-cycle start strobe requests an operation, and an operation select chooses between two forms:

- The long form multiplies the full 32-bit operands.
- The word form multiplies only the low 16 bits of each operand.

A saturation-mode input, normally driven from a processor status bit, applies a clamping rule that is different for each form. The word form marks an overflow by leaving the value 1 in the high word.

The surrounding pipeline can clear both words in one cycle or write either word directly, for example to restore a saved accumulator. Each operation's result appears on the accumulator outputs in the cycle after the start strobe, together with a one-cycle done pulse.

Top module: `smac_unit`

## Requirements
- R1: While reset is high, both accumulator words and done are zero in the following cycle.
- R2: A high `clr` zeroes both words on the next edge and overrides `start`, `ld_hi` and `ld_lo`. No done pulse follows a cycle with `clr` high.
- R3: When neither `clr` nor `start` is high, `ld_hi` writes `ld_hi_val` into the high word and `ld_lo` writes `ld_lo_val` into the low word, each independently. When `start` is high, the loads are ignored.
- R4: With `op_word`=0 (long form) and `sat_en`=0, the accumulator becomes the wrapped 64-bit sum of the accumulator and the signed 32x32 product.
- R5: With `op_word`=1 (word form), only bits 15..0 of each operand are used, sign-extended; bits 31..16 have no effect. With `sat_en`=0, the wrapped 64-bit sum is kept.
- R6: Long form with `sat_en`=1 and a negative sum: bits 31..16 of the high word are forced to ones, and the low word is the sum's low word.
- R7: Long form with `sat_en`=1 and a non-negative sum: the high word keeps only its bits 14..0, and the rest are cleared.
- R8: Word form with `sat_en`=1 and a sum below -2^31: the high word becomes 1 and the low word becomes 0x80000000.
- R9: Word form with `sat_en`=1 and a sum above 0x7FFFFFFF: the high word becomes 1 and the low word becomes 0x7FFFFFFF.
- R10: Word form with `sat_en`=1 and a sum inside [-2^31, 2^31-1]: the full 64-bit sum is kept, with the high word as the sign extension of the low word.
- R11: The result of a start is visible on the outputs one cycle later, with `done` high for exactly that cycle. With no strobe high, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operation request strobe |
| op_word | input | 1 | 0 = long form, 1 = word form |
| sat_en | input | 1 | Saturation mode |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| clr | input | 1 | Synchronous clear of both words |
| ld_hi | input | 1 | Write strobe for the high word |
| ld_lo | input | 1 | Write strobe for the low word |
| ld_hi_val | input | 32 | Data for the high-word write |
| ld_lo_val | input | 32 | Data for the low-word write |
| acc_hi | output | 32 | Accumulator bits 63..32 |
| acc_lo | output | 32 | Accumulator bits 31..0 |
| done | output | 1 | One-cycle pulse when a result is written |

## Verification
The bench builds the unit with its default widths: 32-bit operands and 16-bit halves for the word form. With these widths, the word-form limits at ±2^31 and the 16/15-bit masks of the long form match the requirement values exactly.

Direct word loads put the accumulator right next to each saturation boundary. This makes a single small product enough to cross that boundary, so both clamp directions and the in-range case are reached in one operation each. Random mixes of forms, modes, clears and loads then run against a behavioural 64-bit model.

// File: rtl/smac_pkg.sv
package smac_pkg;

    typedef enum logic {
        MAC_LONG = 1'b0,
        MAC_WORD = 1'b1
    } mac_op_e;

    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_LOW  = 2'd1,
        CLAMP_HIGH = 2'd2
    } clamp_e;

    typedef enum logic [1:0] {
        ACC_HOLD  = 2'd0,
        ACC_CLEAR = 2'd1,
        ACC_RESLT = 2'd2,
        ACC_LOAD  = 2'd3
    } acc_act_e;

    function automatic acc_act_e pick_action(input logic clr, input logic start,
                                             input logic ld_any);
        if (clr)         return ACC_CLEAR;
        else if (start)  return ACC_RESLT;
        else if (ld_any) return ACC_LOAD;
        else             return ACC_HOLD;
    endfunction

endpackage

// File: rtl/smac_mult.sv
module smac_mult
    import smac_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  mac_op_e         op,
    output logic [2*DW-1:0] prod
);
    localparam int AW = 2 * DW;

    logic signed [AW-1:0] ext_a_long, ext_b_long;
    logic signed [AW-1:0] ext_a_half, ext_b_half;
    logic signed [AW-1:0] prod_long, prod_half;

    always_comb begin
        ext_a_long = $signed({{(AW-DW){a[DW-1]}}, a});
        ext_b_long = $signed({{(AW-DW){b[DW-1]}}, b});
        ext_a_half = $signed({{(AW-HW){a[HW-1]}}, a[HW-1:0]});
        ext_b_half = $signed({{(AW-HW){b[HW-1]}}, b[HW-1:0]});
        prod_long  = ext_a_long * ext_b_long;
        prod_half  = ext_a_half * ext_b_half;
        prod       = (op == MAC_WORD) ? prod_half : prod_long;
    end

endmodule

// File: rtl/smac_sat.sv
module smac_sat
    import smac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2*DW-1:0] acc,
    input  logic [2*DW-1:0] prod,
    input  mac_op_e         op,
    input  logic            sat_en,
    output logic [DW-1:0]   res_hi,
    output logic [DW-1:0]   res_lo
);
    localparam int AW      = 2 * DW;
    localparam int N_ONES  = DW / 2;
    localparam int N_KEEP  = DW / 2 - 1;
    localparam logic [DW-1:0] ONES_MASK = {{N_ONES{1'b1}}, {(DW-N_ONES){1'b0}}};
    localparam logic [DW-1:0] KEEP_MASK = {{(DW-N_KEEP){1'b0}}, {N_KEEP{1'b1}}};
    localparam logic [DW-1:0] FLAG_HI   = DW'(1);
    localparam logic [DW-1:0] MIN_LO    = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAX_LO    = {1'b0, {(DW-1){1'b1}}};

    logic [AW-1:0] sum;
    logic          neg;
    logic          fits;
    clamp_e        clamp;

    always_comb begin
        sum  = acc + prod;
        neg  = sum[AW-1];
        fits = (&sum[AW-1:DW-1]) | ~(|sum[AW-1:DW-1]);
        if (fits)     clamp = CLAMP_NONE;
        else if (neg) clamp = CLAMP_LOW;
        else          clamp = CLAMP_HIGH;
    end

    always_comb begin
        res_hi = sum[AW-1:DW];
        res_lo = sum[DW-1:0];
        if (sat_en) begin
            if (op == MAC_LONG) begin
                if (neg) res_hi = sum[AW-1:DW] | ONES_MASK;
                else     res_hi = sum[AW-1:DW] & KEEP_MASK;
            end else begin
                unique case (clamp)
                    CLAMP_LOW: begin
                        res_hi = FLAG_HI;
                        res_lo = MIN_LO;
                    end
                    CLAMP_HIGH: begin
                        res_hi = FLAG_HI;
                        res_lo = MAX_LO;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/smac_accreg.sv
module smac_accreg
    import smac_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_act_e      act,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic [DW-1:0] ld_hi_val,
    input  logic [DW-1:0] ld_lo_val,
    input  logic [DW-1:0] res_hi,
    input  logic [DW-1:0] res_lo,
    output logic [DW-1:0] q_hi,
    output logic [DW-1:0] q_lo,
    output logic          q_done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_hi   <= '0;
            q_lo   <= '0;
            q_done <= 1'b0;
        end else begin
            q_done <= (act == ACC_RESLT);
            unique case (act)
                ACC_CLEAR: begin
                    q_hi <= '0;
                    q_lo <= '0;
                end
                ACC_RESLT: begin
                    q_hi <= res_hi;
                    q_lo <= res_lo;
                end
                ACC_LOAD: begin
                    if (ld_hi) q_hi <= ld_hi_val;
                    if (ld_lo) q_lo <= ld_lo_val;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smac_unit.sv
module smac_unit
    import smac_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_word,
    input  logic          sat_en,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          clr,
    input  logic          ld_hi,
    input  logic          ld_lo,
    input  logic [DW-1:0] ld_hi_val,
    input  logic [DW-1:0] ld_lo_val,
    output logic [DW-1:0] acc_hi,
    output logic [DW-1:0] acc_lo,
    output logic          done
);
    localparam int AW = 2 * DW;

    mac_op_e       op;
    acc_act_e      act;
    logic [AW-1:0] prod;
    logic [DW-1:0] res_hi, res_lo;

    assign op  = mac_op_e'(op_word);
    assign act = pick_action(clr, start, ld_hi | ld_lo);

    smac_mult #(.DW(DW), .HW(HW)) u_mult (
        .a    (opnd_a),
        .b    (opnd_b),
        .op   (op),
        .prod (prod)
    );

    smac_sat #(.DW(DW)) u_sat (
        .acc    ({acc_hi, acc_lo}),
        .prod   (prod),
        .op     (op),
        .sat_en (sat_en),
        .res_hi (res_hi),
        .res_lo (res_lo)
    );

    smac_accreg #(.DW(DW)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .ld_hi     (ld_hi),
        .ld_lo     (ld_lo),
        .ld_hi_val (ld_hi_val),
        .ld_lo_val (ld_lo_val),
        .res_hi    (res_hi),
        .res_lo    (res_lo),
        .q_hi      (acc_hi),
        .q_lo      (acc_lo),
        .q_done    (done)
    );

endmodule

// File: rtl/smac_chk.sv
module smac_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          op_word,
    input logic          sat_en,
    input logic          clr,
    input logic          ld_hi,
    input logic          ld_lo,
    input logic [DW-1:0] acc_hi,
    input logic [DW-1:0] acc_lo,
    input logic          done
);
    localparam logic [DW-1:0] MIN_LO = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAX_LO = {1'b0, {(DW-1){1'b1}}};

    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (acc_hi == '0 && acc_lo == '0 && !done));

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_hi == '0 && acc_lo == '0 && !done));

    a_r11_done_src: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(start) && !$past(clr)));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!start && !clr && !ld_hi && !ld_lo) |=> ($stable(acc_hi) && $stable(acc_lo)));

    // R6 and R7: the high word after a saturated long operation
    a_r6_r7_long_sat: assert property (@(posedge clk) disable iff (rst)
        (start && !clr && !op_word && sat_en) |=>
            ((&acc_hi[DW-1:DW/2]) || (acc_hi[DW-1:DW/2-1] == '0)));

    // R8, R9 and R10: the result of a saturated word operation
    a_r8_r9_word_sat: assert property (@(posedge clk) disable iff (rst)
        (start && !clr && op_word && sat_en) |=>
            ((acc_hi == {DW{acc_lo[DW-1]}}) ||
             (acc_hi == DW'(1) && (acc_lo == MIN_LO || acc_lo == MAX_LO))));

endmodule

bind smac_unit smac_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_word (op_word),
    .sat_en  (sat_en),
    .clr     (clr),
    .ld_hi   (ld_hi),
    .ld_lo   (ld_lo),
    .acc_hi  (acc_hi),
    .acc_lo  (acc_lo),
    .done    (done)
);

// File: tb/sim_smac_unit.sv
module sim_smac_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, op_word = 1'b0, sat_en = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        clr = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
    logic [31:0] ld_hi_val = '0, ld_lo_val = '0;
    logic [31:0] acc_hi, acc_lo;
    logic        done;

    int total = 0;
    int bad   = 0;
    logic [63:0] m_acc = '0;
    logic        m_done = 1'b0;

    always #5 clk = ~clk;

    smac_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op_word(op_word), .sat_en(sat_en),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .clr(clr), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .ld_hi_val(ld_hi_val), .ld_lo_val(ld_lo_val),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .done(done)
    );

    task automatic check(input string tag);
        total++;
        if (acc_hi !== m_acc[63:32] || acc_lo !== m_acc[31:0] || done !== m_done) begin
            bad++;
            $display("FAIL %s: got hi=%h lo=%h done=%b, want hi=%h lo=%h done=%b",
                     tag, acc_hi, acc_lo, done, m_acc[63:32], m_acc[31:0], m_done);
        end
    endtask

    function automatic logic [63:0] model_op(input logic [63:0] acc, input logic w,
                                             input logic s, input logic [31:0] a,
                                             input logic [31:0] b);
        longint p, sum;
        logic [63:0] r;
        if (w) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        else   p = longint'($signed(a)) * longint'($signed(b));
        sum = longint'(acc) + p;
        r = 64'(sum);
        if (s && !w) begin
            if (sum < 0) r[63:48] = 16'hFFFF;
            else         r[63:47] = '0;
        end else if (s && w) begin
            if (sum < -longint'(32'h8000_0000))     r = {32'd1, 32'h8000_0000};
            else if (sum > longint'(32'h7FFF_FFFF)) r = {32'd1, 32'h7FFF_FFFF};
        end
        return r;
    endfunction

    task automatic step(input string tag, input logic st, input logic w, input logic s,
                        input logic [31:0] a, input logic [31:0] b, input logic c,
                        input logic lh, input logic ll, input logic [31:0] hv,
                        input logic [31:0] lv);
        start = st; op_word = w; sat_en = s; opnd_a = a; opnd_b = b;
        clr = c; ld_hi = lh; ld_lo = ll; ld_hi_val = hv; ld_lo_val = lv;
        @(posedge clk);
        if (c) begin
            m_acc = '0; m_done = 1'b0;
        end else if (st) begin
            m_acc = model_op(m_acc, w, s, a, b); m_done = 1'b1;
        end else begin
            if (lh) m_acc[63:32] = hv;
            if (ll) m_acc[31:0]  = lv;
            m_done = 1'b0;
        end
        @(negedge clk);
        start = 0; clr = 0; ld_hi = 0; ld_lo = 0;
        check(tag);
    endtask

    task automatic op(input string tag, input logic w, input logic s,
                      input logic [31:0] a, input logic [31:0] b);
        step(tag, 1, w, s, a, b, 0, 0, 0, '0, '0);
    endtask

    task automatic load(input string tag, input logic [31:0] hv, input logic [31:0] lv);
        step(tag, 0, 0, 0, '0, '0, 0, 1, 1, hv, lv);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, '0, '0, 0, 0, 0, '0, '0);
    endtask

    task automatic wipe(input string tag);
        step(tag, 0, 0, 0, '0, '0, 1, 0, 0, '0, '0);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got no finish, want finish before timeout");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        m_acc = '0; m_done = 1'b0;
        check("R1");
        rst = 1'b0;
        idle("R1");

        // R3: word loads, separately and together
        load("R3", 32'h1234_5678, 32'h9ABC_DEF0);
        step("R3", 0, 0, 0, '0, '0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0BAD_F00D);
        step("R3", 0, 0, 0, '0, '0, 0, 1, 0, 32'hCAFE_0001, 32'h1111_1111);
        // R3: a start takes precedence over the loads
        step("R3", 1, 0, 0, 32'd2, 32'd3, 0, 1, 1, 32'hDEAD_BEEF, 32'hDEAD_BEEF);

        // R2: clear beats start and loads
        step("R2", 1, 0, 0, 32'd5, 32'd5, 1, 1, 1, 32'h1, 32'h2);

        // R4: long form, no saturation
        op("R4", 0, 0, 32'hFFFF_FFFD, 32'd7);
        op("R4", 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        op("R4", 0, 0, 32'h8000_0000, 32'h8000_0000);

        // R5: upper halves ignored in word form
        wipe("R2");
        op("R5", 1, 0, 32'hABCD_0005, 32'h1234_FFFE);
        op("R5", 1, 0, 32'hFFFF_8000, 32'h0000_8000);

        // R6: negative sum forces upper 16 bits of the high word
        load("R6", 32'h8000_0000, 32'h0);
        op("R6", 0, 1, 32'd1, 32'd1);

        // R7: non-negative sum keeps 15 bits of the high word
        load("R7", 32'h1234_5678, 32'h0);
        op("R7", 0, 1, 32'd1, 32'd1);

        // R8: below the lower word-form limit
        load("R8", 32'hFFFF_FFFF, 32'h8000_0000);
        op("R8", 1, 1, 32'd1, 32'h0000_FFFF);

        // R9: above the upper word-form limit, then again from the flagged state
        load("R9", 32'h0, 32'h7FFF_FFF0);
        op("R9", 1, 1, 32'h100, 32'h100);
        op("R9", 1, 1, 32'd0, 32'd0);

        // R10: in range keeps the full sum
        wipe("R2");
        op("R10", 1, 1, 32'hFFFF_FFFD, 32'd4);
        load("R10", 32'h0, 32'h7FFF_FFF0);
        op("R10", 1, 1, 32'd3, 32'd5);

        // R11: back-to-back results and holding while idle
        op("R11", 0, 0, 32'd9, 32'd9);
        op("R11", 1, 0, 32'd9, 32'd9);
        idle("R11");
        idle("R11");

        for (int i = 0; i < 400; i++) begin
            logic          w, s, st, c, lh, ll;
            logic [31:0]   a, b;
            string         tag;
            w  = 1'($urandom);
            s  = 1'($urandom);
            st = ($urandom_range(0, 3) != 0);
            c  = ($urandom_range(0, 15) == 0);
            lh = ($urandom_range(0, 5) == 0);
            ll = ($urandom_range(0, 5) == 0);
            a  = ($urandom_range(0, 1) == 0) ? $urandom : 32'($urandom_range(0, 300)) - 32'd150;
            b  = ($urandom_range(0, 1) == 0) ? $urandom : 32'($urandom_range(0, 300)) - 32'd150;
            if (c)                   tag = "R2";
            else if (!st)            tag = (lh || ll) ? "R3" : "R11";
            else if (!w && !s)       tag = "R4";
            else if (w && !s)        tag = "R5";
            else if (!w)             tag = "R7";
            else                     tag = "R9";
            step(tag, st, w, s, a, b, c, lh, ll, $urandom, $urandom);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule